// File: doc/BRIEF.md
# Programmable Multiplier Watchdog Timer

This block watches a processor for signs of life. Software programs a single 8-bit configuration register with a timeout. The timeout is the product of a 5-bit multiplier and one of four base units, from a sixteenth of a second up to four seconds. If neither a read nor a write of that register arrives before the timeout elapses, the block sets a watchdog flag. It then raises one of two active-low outputs: an interrupt or a reset request.

Time is counted from a 32.768 kHz tick enable. A prescaler first divides that tick into sixteenth-second units. A unit counter then compares the elapsed units against the programmed limit.

A steering bit selects the response to a timeout:
- In interrupt mode, the interrupt stays asserted until software reads the flags register or touches the watchdog register.
- In reset mode, the reset request is a pulse of a fixed, parameterised number of ticks. The count starts again from zero once the pulse ends.

A configuration of zero, or any configuration with a zero multiplier, stops the timer. The register powers up as zero, so the watchdog is off until software arms it.

Top module: `cpu_watchdog`

## Requirements
- R1: After the synchronous reset, the register reads 0x00, the flag is 0, and both `irq_n` and `rst_req_n` are 1.
- R2: A write stores the byte, and it reads back on `wd_rdata` one edge later. Bit 7 is the steering bit, bits 6:2 are the multiplier and bits 1:0 are the resolution code.
- R3: The flag rises exactly M × U × TICKS_PER_UNIT tick-enable cycles after the access edge. M is the multiplier, and U is 1, 4, 16 or 64 for resolution codes 00, 01, 10 and 11.
- R4: Any access to the watchdog register restarts the full timeout, whether it is a read (`wd_acc` with `wd_we`=0) or a write.
- R5: With steering bit 0, a timeout drives `irq_n` low. `irq_n` and the flag stay active until an edge with `flags_rd` or `wd_acc` high clears both.
- R6: With steering bit 1, a timeout sets the flag and drives `rst_req_n` low for RST_TICKS tick cycles while `irq_n` stays high. The count is held while the pulse is active and restarts from zero when it ends.
- R7: A register value with a zero multiplier (including 0x00) never produces a timeout.
- R8: When a flags read coincides with a timeout edge, the flag is still set.
- R9: The count advances only on cycles where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz tick |
| wd_acc | input | 1 | Access strobe for the watchdog register (read or write) |
| wd_we | input | 1 | Write qualifier for `wd_acc` |
| wd_wdata | input | 8 | Write data for the watchdog register |
| wd_rdata | output | 8 | Current watchdog register value |
| flags_rd | input | 1 | Read strobe of the flags register; clears the flag |
| wd_flag | output | 1 | Watchdog timeout flag |
| irq_n | output | 1 | Active-low interrupt |
| rst_req_n | output | 1 | Active-low reset request |

## Verification
When `tick_en` is high on every cycle, the flag and the selected output change on the Nth rising edge after the access edge, where N = M × U × TICKS_PER_UNIT. The bench samples one cycle before that edge, expecting no flag, and again just after it. Clears and readback take effect on the edge that samples the strobe. The reset pulse ends RST_TICKS edges after the timeout edge, and the next timeout follows a full period after that.

All sampling is on the falling clock edge, after counting the rising edges since the stimulus. A small TICKS_PER_UNIT keeps the longest timeout to a few thousand cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CFG_W  = 8;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  // widest unit limit: max multiplier shifted by the largest resolution step
  localparam int UNIT_W = MULT_W + 2 * ((1 << RES_W) - 1);

  typedef struct packed {
    logic              steer;
    logic [MULT_W-1:0] mult;
    logic [RES_W-1:0]  res;
  } wdt_cfg_t;

  // timeout in sixteenth-second units: mult * 4^res
  function automatic logic [UNIT_W-1:0] wdt_limit(input wdt_cfg_t c);
    logic [UNIT_W-1:0] m;
    m = UNIT_W'(c.mult);
    return m << (2 * c.res);
  endfunction
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output wdt_cfg_t         cfg,
  output logic             restart,
  output logic             enabled
);
  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else if (acc && we) cfg <= wdt_cfg_t'(wdata);
  end

  assign restart = acc;
  assign enabled = (cfg.mult != '0);

  // R1
  cfg_por_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg == '0));

  // R2
  cfg_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && we) |=> (cfg == wdt_cfg_t'($past(wdata))));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICKS_PER_UNIT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  output logic unit_tick
);
  localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;

  logic [PW-1:0] cnt;
  logic          last;

  assign last      = (cnt == PW'(TICKS_PER_UNIT - 1));
  assign unit_tick = tick && last && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (tick) cnt <= last ? '0 : cnt + 1'b1;
  end

  // R9
  presc_tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clear) |=> $stable(cnt));
endmodule

// File: rtl/wdt_unit_counter.sv
module wdt_unit_counter
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              unit_tick,
  input  logic [UNIT_W-1:0] limit,
  output logic              timeout
);
  logic [UNIT_W-1:0] cnt;
  logic              hit;

  assign hit     = (UNIT_W'(cnt + 1'b1) == limit);
  assign timeout = unit_tick && hit;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (unit_tick) cnt <= hit ? '0 : cnt + 1'b1;
  end

  // R3
  cnt_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
    (limit != '0) |-> (cnt < limit));

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt == '0));

  // R7
  no_tmo_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (limit == '0) |-> !timeout);
endmodule

// File: rtl/wdt_out_stage.sv
module wdt_out_stage #(
  parameter int RST_TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic timeout,
  input  logic steer,
  input  logic clr,
  output logic flag,
  output logic irq_n,
  output logic rst_req_n,
  output logic hold
);
  localparam int PCW = (RST_TICKS > 1) ? $clog2(RST_TICKS) : 1;

  logic           irq_act;
  logic           rst_act;
  logic [PCW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      irq_act <= 1'b0;
    end else begin
      if (timeout) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (timeout && !steer) irq_act <= 1'b1;
      else if (clr) irq_act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_act <= 1'b0;
      pcnt    <= '0;
    end else if (timeout && steer) begin
      rst_act <= 1'b1;
      pcnt    <= '0;
    end else if (rst_act && tick) begin
      if (pcnt == PCW'(RST_TICKS - 1)) rst_act <= 1'b0;
      else pcnt <= pcnt + 1'b1;
    end
  end

  assign irq_n     = ~irq_act;
  assign rst_req_n = ~rst_act;
  assign hold      = rst_act;

  // R5
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_act |-> flag);

  // R6
  outputs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(irq_act && rst_act));

  // R6
  rst_from_steer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_act) |-> $past(steer));

  // R8
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    timeout |=> flag);
endmodule

// File: rtl/cpu_watchdog.sv
module cpu_watchdog
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 2048,
  parameter int RST_TICKS      = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wd_acc,
  input  logic             wd_we,
  input  logic [CFG_W-1:0] wd_wdata,
  output logic [CFG_W-1:0] wd_rdata,
  input  logic             flags_rd,
  output logic             wd_flag,
  output logic             irq_n,
  output logic             rst_req_n
);
  wdt_cfg_t          cfg;
  logic              restart;
  logic              enabled;
  logic              hold;
  logic              clear;
  logic              unit_tick;
  logic              timeout;
  logic [UNIT_W-1:0] limit;

  wdt_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .acc(wd_acc), .we(wd_we), .wdata(wd_wdata),
    .cfg(cfg), .restart(restart), .enabled(enabled)
  );

  assign wd_rdata = cfg;
  assign limit    = wdt_limit(cfg);
  assign clear    = restart || !enabled || hold;

  wdt_prescaler #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_presc (
    .clk(clk), .rst(rst), .tick(tick_en), .clear(clear), .unit_tick(unit_tick)
  );

  wdt_unit_counter u_cnt (
    .clk(clk), .rst(rst), .clear(clear), .unit_tick(unit_tick),
    .limit(limit), .timeout(timeout)
  );

  wdt_out_stage #(.RST_TICKS(RST_TICKS)) u_out (
    .clk(clk), .rst(rst), .tick(tick_en), .timeout(timeout),
    .steer(cfg.steer), .clr(flags_rd || wd_acc),
    .flag(wd_flag), .irq_n(irq_n), .rst_req_n(rst_req_n), .hold(hold)
  );
endmodule

// File: tb/test_cpu_watchdog.sv
module test_cpu_watchdog;
  localparam int TPU  = 4;
  localparam int RSTT = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en;
  logic       tick_mode = 1'b0;
  logic       wd_acc = 1'b0;
  logic       wd_we = 1'b0;
  logic [7:0] wd_wdata = '0;
  logic [7:0] wd_rdata;
  logic       flags_rd = 1'b0;
  logic       wd_flag, irq_n, rst_req_n;
  int         nchk = 0;
  int         nerr = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) tick_en <= tick_mode ? ~tick_en : 1'b1;

  cpu_watchdog #(.TICKS_PER_UNIT(TPU), .RST_TICKS(RSTT)) i_cpu_watchdog (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wd_acc(wd_acc), .wd_we(wd_we),
    .wd_wdata(wd_wdata), .wd_rdata(wd_rdata), .flags_rd(flags_rd),
    .wd_flag(wd_flag), .irq_n(irq_n), .rst_req_n(rst_req_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wd_access(input logic we, input logic [7:0] d);
    @(negedge clk);
    wd_acc = 1'b1; wd_we = we; wd_wdata = d;
    @(negedge clk);
    wd_acc = 1'b0; wd_we = 1'b0;
  endtask

  task automatic do_flags_read();
    @(negedge clk);
    flags_rd = 1'b1;
    @(negedge clk);
    flags_rd = 1'b0;
  endtask

  function automatic int period(input logic [7:0] d);
    return int'(d[6:2]) * (1 << (2 * int'(d[1:0]))) * TPU;
  endfunction

  task automatic t_reset();
    check("R1 rdata", wd_rdata, 0);
    check("R1 flag", wd_flag, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 rst_req_n", rst_req_n, 1);
    wait_n(300);
    check("R1 idle flag", wd_flag, 0);
  endtask

  task automatic t_timeout(input logic [7:0] d);
    int p;
    p = period(d);
    wd_access(1'b1, d);
    check("R2 readback", wd_rdata, d);
    wait_n(p - 1);
    check("R3 flag early", wd_flag, 0);
    wait_n(1);
    check("R3 flag due", wd_flag, 1);
    check("R5 irq_n low", irq_n, 0);
    check("R5 rst_req_n high", rst_req_n, 1);
    wd_access(1'b0, 8'h00);
    check("R5 flag cleared by access", wd_flag, 0);
    check("R5 irq_n released", irq_n, 1);
  endtask

  task automatic t_irq_hold();
    wd_access(1'b1, 8'h0C);
    wait_n(12);
    check("R5 flag", wd_flag, 1);
    wait_n(5);
    check("R5 irq_n held", irq_n, 0);
    check("R5 flag held", wd_flag, 1);
    do_flags_read();
    check("R5 flag cleared by flags read", wd_flag, 0);
    check("R5 irq_n after flags read", irq_n, 1);
    wd_access(1'b1, 8'h00);
  endtask

  task automatic t_restart();
    wd_access(1'b1, 8'h0C);
    wait_n(9);
    wd_access(1'b0, 8'h00);
    wait_n(11);
    check("R4 read restart early", wd_flag, 0);
    wait_n(1);
    check("R4 read restart due", wd_flag, 1);
    wait_n(5);
    wd_access(1'b1, 8'h10);
    check("R4 write clears flag", wd_flag, 0);
    wait_n(15);
    check("R4 write restart early", wd_flag, 0);
    wait_n(1);
    check("R4 write restart due", wd_flag, 1);
    wd_access(1'b1, 8'h00);
  endtask

  task automatic t_reset_steer();
    wd_access(1'b1, 8'h8C);
    wait_n(11);
    check("R6 rst_req_n before", rst_req_n, 1);
    wait_n(1);
    check("R6 flag", wd_flag, 1);
    check("R6 rst_req_n low", rst_req_n, 0);
    check("R6 irq_n high", irq_n, 1);
    wait_n(RSTT - 1);
    check("R6 pulse still low", rst_req_n, 0);
    wait_n(1);
    check("R6 pulse ended", rst_req_n, 1);
    wait_n(11);
    check("R6 restart early", rst_req_n, 1);
    wait_n(1);
    check("R6 second pulse", rst_req_n, 0);
    wait_n(3);
    wd_access(1'b1, 8'h00);
    check("R6 flag cleared", wd_flag, 0);
    check("R6 rst_req_n idle", rst_req_n, 1);
  endtask

  task automatic t_disabled();
    wd_access(1'b1, 8'h03);
    wait_n(600);
    check("R7 zero mult flag", wd_flag, 0);
    check("R7 zero mult irq_n", irq_n, 1);
    wd_access(1'b1, 8'h80);
    wait_n(300);
    check("R7 zero mult rst_req_n", rst_req_n, 1);
    check("R7 zero mult flag steer", wd_flag, 0);
    wd_access(1'b1, 8'h00);
  endtask

  task automatic t_coincide();
    wd_access(1'b1, 8'h0C);
    wait_n(11);
    flags_rd = 1'b1;
    @(negedge clk);
    flags_rd = 1'b0;
    check("R8 flag survives read", wd_flag, 1);
    check("R8 irq_n", irq_n, 0);
    wd_access(1'b1, 8'h00);
  endtask

  task automatic t_tick_gate();
    tick_mode = 1'b1;
    wd_access(1'b1, 8'h0C);
    wait_n(22);
    check("R9 half rate early", wd_flag, 0);
    wait_n(4);
    check("R9 half rate due", wd_flag, 1);
    tick_mode = 1'b0;
    wd_access(1'b1, 8'h00);
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    t_reset();
    t_timeout(8'h04);
    t_timeout(8'h0C);
    t_timeout(8'h09);
    t_timeout(8'h06);
    t_timeout(8'h07);
    t_timeout(8'h0E);
    t_timeout(8'h7F);
    t_irq_hold();
    t_restart();
    t_reset_steer();
    t_disabled();
    t_coincide();
    t_tick_gate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule